// File: doc/BRIEF.md
# Tiny Eight-Opcode 8-bit CPU

This block is a very small 8-bit processor core. It has four 8-bit working registers and two condition flags, zero and carry. It fetches one- and two-byte instructions from a 2 KB byte-addressed memory and executes a fixed set of eight operations:

- load from an absolute address and store to an absolute address;
- register move;
- add and add-with-carry;
- compare;
- conditional (zero) relative jump and unconditional relative jump.

The memory lives outside the block and is reached through a single synchronous port. The core drives an 11-bit address and may raise a write strobe with write data. Read data must be returned on the clock cycle after the address was presented. For observation, the four registers, the program counter and both flags are brought out on debug outputs.

Execution is sequential and multi-cycle:

| Instruction kind | Cycles |
|---|---|
| Register-to-register | 2 |
| Jump | 3 |
| Store | 4 |
| Load | 5 |

A program can park itself in a jump-to-self loop; the debug program counter then holds the address of that jump.

Top module: `tiny8_cpu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the program counter, all four registers and both flags read 0; the first fetch is from address 0.
- R2: A one-byte register form is laid out as opcode in bits 7:5, an ignored bit 4, destination (or left operand) in bits 3:2 and source (or right operand) in bits 1:0. Opcode 001 (move) copies the source to the destination and leaves both flags unchanged.
- R3: Opcode 010 (add) writes (dst+src) mod 256 to the destination. It sets carry to the carry out of bit 7 and zero when the written result is 0. The previous carry is not used.
- R4: Opcode 011 (add with carry) behaves like add but also adds the current carry flag as an extra 1.
- R5: Opcode 101 (compare) computes left minus right. It sets zero when the operands are equal and carry when left < right (unsigned borrow). It writes no register.
- R6: Opcode 000 (load) is two bytes. The first byte holds the register in bits 4:3 and address bits 10:8 in bits 2:0; the second byte holds address bits 7:0. The loaded byte goes to the register and the flags are unchanged.
- R7: Opcode 100 (store) has the same layout as load. It writes the register to the 11-bit address with exactly one write strobe cycle, and changes neither registers nor flags.
- R8: Opcode 110 (jump if zero) is two bytes with an 11-bit two's complement offset: bits 2:0 of the first byte (bit 2 is the sign) followed by the second byte. The offset is added to the address after the jump. The jump is taken only when the zero flag is 1; otherwise execution continues at that next address.
- R9: Opcode 111 (jump) uses the same offset encoding as R8 and is always taken; offset -2 (bytes E7 FE) forms a self-loop.
- R10: Program counter arithmetic, for both sequential fetch and jump targets, wraps modulo 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 11 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe for `mem_addr` |
| dbg_regs | output | 32 | Registers: r3 in bits 31:24 down to r0 in bits 7:0 |
| dbg_pc | output | 11 | Program counter |
| dbg_zero | output | 1 | Zero flag |
| dbg_carry | output | 1 | Carry flag |

## Verification
The block has no parameters, so the bench builds it exactly as it will be used: an 11-bit address space backed by a full 2048-byte memory model. With the whole address space present, the bench can place code in the top bytes of memory and jump across the end, which exercises modulo-2048 wraparound of jump targets. Arithmetic vectors cover carry out, carry in, a zero result and compare borrow.

// File: rtl/tiny8_cpu.sv
module tiny8_cpu (
  input  logic        clk,
  input  logic        rst,
  output logic [10:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [31:0] dbg_regs,
  output logic [10:0] dbg_pc,
  output logic        dbg_zero,
  output logic        dbg_carry
);
  localparam logic [2:0] OP_LD = 3'd0, OP_MOV = 3'd1, OP_ADD = 3'd2, OP_ADC = 3'd3;
  localparam logic [2:0] OP_ST = 3'd4, OP_CMP = 3'd5, OP_JZ = 3'd6, OP_JMP = 3'd7;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_EXT, S_MEM, S_LOAD} state_t;

  state_t      state;
  logic [7:0]  rf [4];
  logic [10:0] pc;
  logic [7:0]  ir, lo;
  logic        zf, cf;

  logic [2:0]  dop, xop;
  logic [7:0]  opa, opb;
  logic [8:0]  sum9, dif9;
  logic        two_byte, taken;
  logic [10:0] tgt;

  assign dop      = mem_rdata[7:5];
  assign xop      = ir[7:5];
  assign opa      = rf[mem_rdata[3:2]];
  assign opb      = rf[mem_rdata[1:0]];
  assign sum9     = {1'b0, opa} + {1'b0, opb} + {8'd0, (dop == OP_ADC) && cf};
  assign dif9     = {1'b0, opa} - {1'b0, opb};
  assign two_byte = (dop == OP_LD) || (dop == OP_ST) || (dop == OP_JZ) || (dop == OP_JMP);
  assign tgt      = pc + 11'd2 + {ir[2:0], mem_rdata};
  assign taken    = (xop == OP_JMP) || ((xop == OP_JZ) && zf);

  always_comb begin
    case (state)
      S_FETCH: mem_addr = pc;
      S_DEC:   mem_addr = pc + 11'd1;
      S_MEM:   mem_addr = {ir[2:0], lo};
      default: mem_addr = pc;
    endcase
  end

  assign mem_we    = (state == S_MEM) && (xop == OP_ST);
  assign mem_wdata = rf[ir[4:3]];

  assign dbg_regs  = {rf[3], rf[2], rf[1], rf[0]};
  assign dbg_pc    = pc;
  assign dbg_zero  = zf;
  assign dbg_carry = cf;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      lo    <= '0;
      zf    <= 1'b0;
      cf    <= 1'b0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          ir <= mem_rdata;
          if (two_byte) begin
            state <= S_EXT;
          end else begin
            pc    <= pc + 11'd1;
            state <= S_FETCH;
            case (dop)
              OP_MOV: rf[mem_rdata[3:2]] <= opb;
              OP_ADD, OP_ADC: begin
                rf[mem_rdata[3:2]] <= sum9[7:0];
                zf <= (sum9[7:0] == 8'd0);
                cf <= sum9[8];
              end
              OP_CMP: begin
                zf <= (dif9[7:0] == 8'd0);
                cf <= dif9[8];
              end
              default: ;
            endcase
          end
        end
        S_EXT: begin
          lo    <= mem_rdata;
          pc    <= taken ? tgt : pc + 11'd2;
          state <= ((xop == OP_LD) || (xop == OP_ST)) ? S_MEM : S_FETCH;
        end
        S_MEM: state <= (xop == OP_ST) ? S_FETCH : S_LOAD;
        S_LOAD: begin
          rf[ir[4:3]] <= mem_rdata;
          state       <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == 11'd0 && dbg_regs == 32'd0 && !zf && !cf)); // R1
  AST_MOV_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && dop == OP_MOV) |=> ($stable(zf) && $stable(cf))); // R2
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && dop == OP_CMP) |=> $stable(dbg_regs)); // R5
  AST_STORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> ($stable(dbg_regs) && $stable(zf) && $stable(cf))); // R7
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R7
  AST_JZ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXT && xop == OP_JZ && !zf) |=> (pc == $past(pc) + 11'd2)); // R8
endmodule

// File: tb/tiny8_cpu_test.sv
module tiny8_cpu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [31:0] dbg_regs;
  logic [10:0] dbg_pc;
  logic        dbg_zero, dbg_carry;

  logic [7:0]  mem [2048];
  logic        bw_en = 1'b0, clr_all = 1'b0;
  logic [10:0] bw_addr = '0;
  logic [7:0]  bw_data = '0;
  int          checks = 0, failures = 0, p = 0;

  always #5 clk = ~clk;

  tiny8_cpu uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .dbg_regs(dbg_regs),
    .dbg_pc(dbg_pc), .dbg_zero(dbg_zero), .dbg_carry(dbg_carry)
  );

  always @(posedge clk) begin
    if (clr_all) begin
      for (int i = 0; i < 2048; i++) mem[i] <= 8'h00;
    end else if (bw_en) begin
      mem[bw_addr] <= bw_data;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr];
  end

  // {op(0 add,1 adc,2 cmp), carry in, a, b, expected r0, expected Z, expected C}
  localparam logic [28:0] VEC [10] = '{
    {2'd0, 1'b0, 8'h12, 8'h34, 8'h46, 1'b0, 1'b0},
    {2'd0, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1},
    {2'd0, 1'b0, 8'h80, 8'h90, 8'h10, 1'b0, 1'b1},
    {2'd0, 1'b1, 8'h01, 8'h01, 8'h02, 1'b0, 1'b0},
    {2'd1, 1'b1, 8'h10, 8'h20, 8'h31, 1'b0, 1'b0},
    {2'd1, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1},
    {2'd1, 1'b0, 8'h7F, 8'h01, 8'h80, 1'b0, 1'b0},
    {2'd2, 1'b0, 8'h55, 8'h55, 8'h55, 1'b1, 1'b0},
    {2'd2, 1'b0, 8'h10, 8'h20, 8'h10, 1'b0, 1'b1},
    {2'd2, 1'b0, 8'h20, 8'h10, 8'h20, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [10:0] a, input logic [7:0] b);
    bw_en = 1'b1; bw_addr = a; bw_data = b;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic emit(input logic [7:0] b);
    put(p[10:0], b);
    p = (p + 1) % 2048;
  endtask

  task automatic emit_mem(input logic [2:0] op, input logic [1:0] r, input logic [10:0] a);
    emit({op, r, a[10:8]});
    emit(a[7:0]);
  endtask

  task automatic emit_rr(input logic [2:0] op, input logic [1:0] d, input logic [1:0] s);
    emit({op, 1'b0, d, s});
  endtask

  task automatic emit_jump(input logic [2:0] op, input logic [10:0] off);
    emit({op, 2'b00, off[10:8]});
    emit(off[7:0]);
  endtask

  task automatic new_prog();
    @(negedge clk);
    rst = 1'b1; clr_all = 1'b1;
    @(negedge clk);
    clr_all = 1'b0;
    p = 0;
  endtask

  task automatic run(input int cyc);
    rst = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset regs", dbg_regs, 32'd0);
    chk("R1 reset pc", {21'd0, dbg_pc}, 32'd0);
    chk("R1 reset flags", {30'd0, dbg_zero, dbg_carry}, 32'd0);

    for (int v = 0; v < 10; v++) begin
      string tag;
      logic [28:0] e;
      e = VEC[v];
      tag = (e[28:27] == 2'd0) ? "R3" : (e[28:27] == 2'd1) ? "R4" : "R5";
      new_prog();
      emit_mem(3'b000, 2'd0, 11'h700);
      emit_mem(3'b000, 2'd1, 11'h701);
      emit_mem(3'b000, 2'd2, 11'h702);
      emit_mem(3'b000, 2'd3, 11'h703);
      emit_rr(3'b010, 2'd2, 2'd3);
      emit_rr((e[28:27] == 2'd0) ? 3'b010 : (e[28:27] == 2'd1) ? 3'b011 : 3'b101, 2'd0, 2'd1);
      emit_jump(3'b111, 11'h7FE);
      put(11'h700, e[25:18]);
      put(11'h701, e[17:10]);
      put(11'h702, 8'hFF);
      put(11'h703, {7'd0, e[26]});
      run(60);
      chk({tag, " result r0"}, {24'd0, dbg_regs[7:0]}, {24'd0, e[9:2]});
      chk({tag, " flags Z,C"}, {30'd0, dbg_zero, dbg_carry}, {30'd0, e[1:0]});
      chk({tag, " src r1 kept"}, {24'd0, dbg_regs[15:8]}, {24'd0, e[17:10]});
      chk("R9 self loop pc", {21'd0, dbg_pc}, 32'd10);
    end

    // R2 / R6: move and load leave the flags set by an add
    new_prog();
    emit_mem(3'b000, 2'd0, 11'h700);
    emit_mem(3'b000, 2'd1, 11'h701);
    emit_rr(3'b010, 2'd0, 2'd1);
    emit_rr(3'b001, 2'd2, 2'd1);
    emit_rr(3'b001, 2'd3, 2'd2);
    emit_mem(3'b000, 2'd1, 11'h702);
    emit_jump(3'b111, 11'h7FE);
    put(11'h700, 8'hFF); put(11'h701, 8'h01); put(11'h702, 8'h5A);
    run(60);
    chk("R2 move r2", {24'd0, dbg_regs[23:16]}, 32'h01);
    chk("R2 move r3", {24'd0, dbg_regs[31:24]}, 32'h01);
    chk("R6 load r1", {24'd0, dbg_regs[15:8]}, 32'h5A);
    chk("R2 R6 flags kept", {30'd0, dbg_zero, dbg_carry}, 32'd3);

    // R7: store to a high address
    new_prog();
    emit_mem(3'b000, 2'd0, 11'h700);
    emit_mem(3'b100, 2'd0, 11'h5C3);
    emit_jump(3'b111, 11'h7FE);
    put(11'h700, 8'hA5);
    run(40);
    chk("R7 stored byte", {24'd0, mem[11'h5C3]}, 32'hA5);
    chk("R7 neighbour below", {24'd0, mem[11'h5C2]}, 32'h00);
    chk("R7 neighbour above", {24'd0, mem[11'h5C4]}, 32'h00);
    chk("R7 regs kept", dbg_regs, 32'h000000A5);
    chk("R7 flags kept", {30'd0, dbg_zero, dbg_carry}, 32'd0);

    // R8: jump if zero taken then not taken
    new_prog();
    emit_mem(3'b000, 2'd0, 11'h700);
    emit_mem(3'b000, 2'd1, 11'h701);
    emit_mem(3'b000, 2'd2, 11'h702);
    emit_rr(3'b101, 2'd0, 2'd1);
    emit_jump(3'b110, 11'h001);
    emit_rr(3'b001, 2'd3, 2'd2);
    emit_rr(3'b101, 2'd0, 2'd2);
    emit_jump(3'b110, 11'h001);
    emit_rr(3'b001, 2'd1, 2'd2);
    emit_jump(3'b111, 11'h7FE);
    put(11'h700, 8'h05); put(11'h701, 8'h05); put(11'h702, 8'h77);
    run(60);
    chk("R8 taken skips move", {24'd0, dbg_regs[31:24]}, 32'h00);
    chk("R8 not taken runs move", {24'd0, dbg_regs[15:8]}, 32'h77);
    chk("R8 halt pc", {21'd0, dbg_pc}, 32'd14);

    // R10 / R9: jump backwards across address 0, then forward across the top
    new_prog();
    emit_jump(3'b111, 11'h7FC);
    emit_mem(3'b000, 2'd1, 11'h601);
    emit_mem(3'b000, 2'd0, 11'h600);
    emit_jump(3'b111, 11'h7FE);
    p = 11'h7FE;
    emit_jump(3'b111, 11'h004);
    put(11'h600, 8'h3C); put(11'h601, 8'h99);
    run(40);
    chk("R10 wrapped path loads r0", {24'd0, dbg_regs[7:0]}, 32'h3C);
    chk("R9 skipped load r1", {24'd0, dbg_regs[15:8]}, 32'h00);
    chk("R10 halt pc", {21'd0, dbg_pc}, 32'd6);

    // R1: a second reset clears state left by a program
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 re-reset regs", dbg_regs, 32'd0);
    chk("R1 re-reset pc", {21'd0, dbg_pc}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R1-all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule